// File: doc/BRIEF.md
# FPU Lane Temporal Memoization Unit

This block sits next to one lane of a pipelined single-precision floating-point unit and keeps a short history of that lane's recent clean executions: the opcode, both operands and the result. Every issued instruction is looked up in this history in the same cycle it issues. The hit flag and the recalled result then travel down a delay line that matches the FPU latency, so that they reach the output in the same cycle as the FPU result for that instruction.

When the timing-error detector flags the FPU result, a hit lets the lane take the recalled value in place of the bad one, with no stall. A miss raises a replay request for the normal flush-and-replay recovery. Unflagged results pass through untouched and are written into the history, replacing the oldest entry. A configuration register selects the match rule. In exact matching every opcode and operand bit must agree. In approximate matching the low fraction bits of each operand are ignored. Each lane owns its own copy of the unit, so lanes recover on their own while staying in lock-step.

Top module: `fpu_memo_lane`

## Requirements
- R1: After reset the history is empty, matching is exact, and all outputs are low. An instruction that completes with a flagged error before any clean execution misses and requests replay.
- R2: When a completing result carries no error flag, out_result equals fpu_result, and out_hit and out_replay are both low.
- R3: When a flagged result's instruction matched the history at issue, out_result carries the stored result and out_hit is high with out_replay low. This happens in the cycle fpu_result appears, which is 4 clock edges after the issue edge.
- R4: When a flagged result's instruction missed, out_replay is high, out_hit is low and out_result equals fpu_result.
- R5: In exact mode, a difference in any opcode bit or any operand bit gives a miss.
- R6: In approximate mode, bits 11..0 of each 32-bit operand are left out of the compare, so a difference confined to those bits still hits. A difference in operand bit 12 or above, or in the opcode, misses.
- R7: Only results completing without an error flag are recorded. A flagged execution never creates a hit for a later identical instruction.
- R8: The history holds 4 entries. A clean execution overwrites the oldest entry in round-robin order, so the fifth distinct clean execution evicts the first one.
- R9: A write with cfg_addr = 0 loads the match mode from cfg_wdata bit 0 (1 = approximate, 0 = exact). Writes to any other address leave the mode unchanged.
- R10: In cycles with no completing result, out_hit, out_replay and out_result are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Instruction issued to the FPU this cycle |
| iss_op | input | 6 | Opcode of the issued instruction |
| iss_a | input | 32 | First operand |
| iss_b | input | 32 | Second operand |
| fpu_valid | input | 1 | FPU result present this cycle |
| fpu_result | input | 32 | FPU result |
| fpu_err | input | 1 | Timing-error flag from the detector for this result |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register address |
| cfg_wdata | input | 1 | Configuration write data (bit 0 = approximate mode) |
| out_valid | output | 1 | Corrected result present |
| out_result | output | 32 | Corrected result |
| out_hit | output | 1 | Stored result substituted for a flagged one |
| out_replay | output | 1 | Flagged result with no stored match; replay needed |

## Verification
The checker watches the output selection rules on every cycle. Clean results pass through with no hit or replay. Every flagged result is resolved by exactly one of hit or replay, and a replay carries the raw FPU value. Idle cycles are quiet, the history only fills after reset, and the mode changes only on a write to its own address. Whether a lookup should hit depends on what was stored earlier, so only the bench's scenarios can show it. These scenarios cover the empty history, flagged executions that must not be stored, single-bit operand and opcode changes in both modes, the boundary at operand bit 12, and eviction after four clean executions.

// File: rtl/fpmemo_pkg.sv
package fpmemo_pkg;
    parameter int OP_W     = 6;
    parameter int DATA_W   = 32;
    parameter int ADDR_W   = 4;
    parameter int CFG_W    = 1;
    parameter int LAT      = 4;
    parameter int DEPTH    = 4;
    parameter int IGN_BITS = 12;
    parameter logic [ADDR_W-1:0] MODE_ADDR = '0;

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [OP_W-1:0]   op;
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
    } key_t;

    typedef struct packed {
        logic              vld;
        key_t              key;
        logic [DATA_W-1:0] res;
    } entry_t;

    typedef struct packed {
        logic              vld;
        key_t              key;
        logic              hit;
        logic [DATA_W-1:0] res;
    } stage_t;

    function automatic logic [DATA_W-1:0] cmp_mask(input logic approx);
        logic [DATA_W-1:0] m;
        m = '1;
        if (approx) m[IGN_BITS-1:0] = '0;
        return m;
    endfunction
endpackage

// File: rtl/memo_cfg.sv
module memo_cfg
    import fpmemo_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CFG_W-1:0]  wdata,
    output logic              approx
);
    typedef struct packed {
        logic approx;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we && (addr == MODE_ADDR)) begin
            st_d.approx = wdata[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign approx = st_q.approx;
endmodule

// File: rtl/memo_table.sv
module memo_table
    import fpmemo_pkg::*;
#(
    parameter int N = DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              approx,
    input  key_t              lk_key,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_res,
    input  logic              wr_en,
    input  key_t              wr_key,
    input  logic [DATA_W-1:0] wr_res,
    output logic [N-1:0]      vld_vec
);
    localparam int PW = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        entry_t [N-1:0] ent;
        logic [PW-1:0]  ptr;
    } tbl_state_t;

    tbl_state_t st_d, st_q;
    logic [N-1:0] match;
    logic [DATA_W-1:0] mask;

    assign mask = cmp_mask(approx);

    for (genvar g = 0; g < N; g++) begin : g_cmp
        logic op_eq, a_eq, b_eq;
        assign op_eq = (st_q.ent[g].key.op == lk_key.op);
        assign a_eq  = (((st_q.ent[g].key.a ^ lk_key.a) & mask) == '0);
        assign b_eq  = (((st_q.ent[g].key.b ^ lk_key.b) & mask) == '0);
        assign match[g] = st_q.ent[g].vld && op_eq && a_eq && b_eq;
        assign vld_vec[g] = st_q.ent[g].vld;
    end

    always_comb begin
        lk_hit = 1'b0;
        lk_res = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) begin
                lk_hit = 1'b1;
                lk_res = st_q.ent[i].res;
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.ent[st_q.ptr].vld = 1'b1;
            st_d.ent[st_q.ptr].key = wr_key;
            st_d.ent[st_q.ptr].res = wr_res;
            if (st_q.ptr == PW'(N - 1)) st_d.ptr = '0;
            else                        st_d.ptr = st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/memo_delay.sv
module memo_delay
    import fpmemo_pkg::*;
#(
    parameter int STAGES = LAT
) (
    input  logic   clk,
    input  logic   rst_n,
    input  stage_t din,
    output stage_t dout
);
    typedef struct packed {
        stage_t [STAGES-1:0] pipe;
    } dly_state_t;

    dly_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pipe[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            st_d.pipe[i] = st_q.pipe[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.pipe[STAGES-1];
endmodule

// File: rtl/fpu_memo_lane.sv
module fpu_memo_lane
    import fpmemo_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    input  logic [OP_W-1:0]   iss_op,
    input  logic [DATA_W-1:0] iss_a,
    input  logic [DATA_W-1:0] iss_b,
    input  logic              fpu_valid,
    input  logic [DATA_W-1:0] fpu_result,
    input  logic              fpu_err,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result,
    output logic              out_hit,
    output logic              out_replay
);
    logic              cfg_approx;
    key_t              iss_key;
    logic              lk_hit;
    logic [DATA_W-1:0] lk_res;
    logic              wr_en;
    logic [DEPTH-1:0]  tbl_vld;
    stage_t            stg_in, stg_out;
    logic              done;

    memo_cfg u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .addr   (cfg_addr),
        .wdata  (cfg_wdata),
        .approx (cfg_approx)
    );

    assign iss_key.op = iss_op;
    assign iss_key.a  = iss_a;
    assign iss_key.b  = iss_b;

    memo_table #(.N(DEPTH)) u_tbl (
        .clk     (clk),
        .rst_n   (rst_n),
        .approx  (cfg_approx),
        .lk_key  (iss_key),
        .lk_hit  (lk_hit),
        .lk_res  (lk_res),
        .wr_en   (wr_en),
        .wr_key  (stg_out.key),
        .wr_res  (fpu_result),
        .vld_vec (tbl_vld)
    );

    always_comb begin
        stg_in     = '0;
        stg_in.vld = iss_valid;
        if (iss_valid) begin
            stg_in.key = iss_key;
            stg_in.hit = lk_hit;
            stg_in.res = lk_res;
        end
    end

    memo_delay #(.STAGES(LAT)) u_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (stg_in),
        .dout  (stg_out)
    );

    assign done  = stg_out.vld && fpu_valid;
    assign wr_en = done && !fpu_err;

    always_comb begin
        out_valid  = done;
        out_result = '0;
        out_hit    = 1'b0;
        out_replay = 1'b0;
        if (done) begin
            if (!fpu_err) begin
                out_result = fpu_result;
            end else if (stg_out.hit) begin
                out_result = stg_out.res;
                out_hit    = 1'b1;
            end else begin
                out_result = fpu_result;
                out_replay = 1'b1;
            end
        end
    end
endmodule

// File: rtl/fpu_memo_lane_chk.sv
module fpu_memo_lane_chk
    import fpmemo_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              fpu_err,
    input logic [DATA_W-1:0] fpu_result,
    input logic              cfg_we,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_result,
    input logic              out_hit,
    input logic              out_replay,
    input logic              cfg_approx,
    input logic [DEPTH-1:0]  tbl_vld
);
    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (tbl_vld == '0) && !cfg_approx); // R1
    AST_CLEAN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !fpu_err) |-> (out_result == fpu_result) && !out_hit && !out_replay); // R2
    AST_ERR_RESOLVED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && fpu_err) |-> (out_hit != out_replay)); // R3
    AST_REPLAY_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        out_replay |-> (out_result == fpu_result) && !out_hit); // R4
    AST_FILL_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(tbl_vld) >= $countones($past(tbl_vld))); // R8
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_we && (cfg_addr == MODE_ADDR)) |=> $stable(cfg_approx)); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !out_hit && !out_replay && (out_result == '0)); // R10
endmodule

bind fpu_memo_lane fpu_memo_lane_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fpu_err    (fpu_err),
    .fpu_result (fpu_result),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .out_valid  (out_valid),
    .out_result (out_result),
    .out_hit    (out_hit),
    .out_replay (out_replay),
    .cfg_approx (cfg_approx),
    .tbl_vld    (tbl_vld)
);

// File: tb/fpu_memo_lane_tb.sv
`timescale 1ns/1ps
module fpu_memo_lane_tb;
    localparam logic [31:0] CORR = 32'h00A5_5A00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iss_valid = 1'b0;
    logic [5:0]  iss_op = '0;
    logic [31:0] iss_a = '0, iss_b = '0;
    logic [31:0] tb_res = '0;
    logic        tb_err = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [0:0]  cfg_wdata = '0;
    logic        out_valid, out_hit, out_replay;
    logic [31:0] out_result;

    logic        fp_v [4];
    logic [31:0] fp_r [4];
    logic        fp_e [4];
    logic        fpu_valid, fpu_err;
    logic [31:0] fpu_result;

    int total = 0, bad = 0;
    bit finished = 0;

    typedef struct {
        logic [31:0] res;
        logic        hit;
        logic        rep;
        string       req;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    fpu_memo_lane u_dut (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iss_valid), .iss_op(iss_op), .iss_a(iss_a), .iss_b(iss_b),
        .fpu_valid(fpu_valid), .fpu_result(fpu_result), .fpu_err(fpu_err),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .out_valid(out_valid), .out_result(out_result),
        .out_hit(out_hit), .out_replay(out_replay)
    );

    // FPU and error-detector model: four-stage pipeline
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin
                fp_v[i] <= 1'b0; fp_r[i] <= '0; fp_e[i] <= 1'b0;
            end
        end else begin
            fp_v[0] <= iss_valid;
            fp_r[0] <= tb_err ? (tb_res ^ CORR) : tb_res;
            fp_e[0] <= iss_valid && tb_err;
            for (int i = 1; i < 4; i++) begin
                fp_v[i] <= fp_v[i-1]; fp_r[i] <= fp_r[i-1]; fp_e[i] <= fp_e[i-1];
            end
        end
    end
    assign fpu_valid  = fp_v[3];
    assign fpu_result = fp_r[3];
    assign fpu_err    = fp_e[3];

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: pops expected items when results appear
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (out_valid) begin
                if (sb.size() == 0) begin
                    check("R2 unexpected output", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check({e.req, " result"}, out_result, e.res);
                    check({e.req, " hit"},    {31'd0, out_hit}, {31'd0, e.hit});
                    check({e.req, " replay"}, {31'd0, out_replay}, {31'd0, e.rep});
                end
            end else if (out_hit || out_replay || (out_result != '0)) begin
                check("R10 idle outputs", {30'd0, out_hit, out_replay}, 32'd0);
            end
        end
    end

    task automatic issue(input logic [5:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] good, input logic err,
                         input logic ehit, input logic [31:0] stored, input string req);
        exp_t e;
        iss_valid = 1'b1; iss_op = op; iss_a = a; iss_b = b;
        tb_res = good; tb_err = err;
        e.req = req;
        e.hit = err && ehit;
        e.rep = err && !ehit;
        e.res = !err ? good : (ehit ? stored : (good ^ CORR));
        sb.push_back(e);
        @(negedge clk);
        iss_valid = 1'b0; tb_err = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic cfg_write(input logic [3:0] addr, input logic val);
        cfg_we = 1'b1; cfg_addr = addr; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        logic [31:0] A, B, R;
        A = 32'h3FC0_0001; B = 32'h4120_0800; R = 32'h4270_1234;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet after reset
        check("R1 reset valid", {31'd0, out_valid}, 32'd0);
        check("R1 reset flags", {30'd0, out_hit, out_replay}, 32'd0);
        // R1/R4: empty history misses
        issue(6'd3, A, B, R, 1'b1, 1'b0, '0, "R1 empty miss");
        // R7: flagged execution not recorded
        issue(6'd3, A, B, R, 1'b1, 1'b0, '0, "R7 errant not stored");
        // R2: clean pass-through, recorded
        issue(6'd3, A, B, R, 1'b0, 1'b0, '0, "R2 clean pass");
        // R3: hit substitutes stored result
        issue(6'd3, A, B, R, 1'b1, 1'b1, R, "R3 hit corrects");
        // R5: exact mode single-bit differences miss
        issue(6'd2, A, B, R, 1'b1, 1'b0, '0, "R5 opcode differs");
        issue(6'd3, A ^ 32'h1, B, R, 1'b1, 1'b0, '0, "R5 a bit0 differs");
        issue(6'd3, A, B ^ 32'h8000_0000, R, 1'b1, 1'b0, '0, "R5 b msb differs");
        // R9: write to another address ignored
        cfg_write(4'd5, 1'b1);
        issue(6'd3, A ^ 32'h1, B, R, 1'b1, 1'b0, '0, "R9 other addr ignored");
        // R6: approximate mode
        cfg_write(4'd0, 1'b1);
        issue(6'd3, A ^ 32'hFFF, B ^ 32'h0FF, R, 1'b1, 1'b1, R, "R6 low bits ignored");
        issue(6'd3, A ^ 32'h1000, B, R, 1'b1, 1'b0, '0, "R6 bit12 differs");
        issue(6'd4, A ^ 32'h1, B, R, 1'b1, 1'b0, '0, "R6 opcode still exact");
        // R9: back to exact
        cfg_write(4'd0, 1'b0);
        issue(6'd3, A ^ 32'h1, B, R, 1'b1, 1'b0, '0, "R9 exact restored");
        cfg_write(4'd0, 1'b1);
        // R8: four more clean entries evict the first
        for (int k = 1; k <= 4; k++) begin
            issue(6'd7, 32'h4000_0000 + (k << 16), B, 32'h5000_0000 + k, 1'b0, 1'b0, '0, "R8 fill");
        end
        issue(6'd3, A, B, R, 1'b1, 1'b0, '0, "R8 oldest evicted");
        issue(6'd7, 32'h4001_0000, B, 32'h5000_0001, 1'b1, 1'b1, 32'h5000_0001, "R8 entry1 kept");
        issue(6'd7, 32'h4004_0000, B, 32'h5000_0004, 1'b1, 1'b1, 32'h5000_0004, "R8 newest kept");
        repeat (6) @(negedge clk);
        check("R2 scoreboard drained", sb.size(), 32'd0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL R1 watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule